// File: doc/BRIEF.md
# Halted-Hart Instruction Feed

This block serves a single processor hart while that hart is held in debug halt. Every instruction fetch the halted hart issues is answered here and never by normal memory. An external debugger drives execution through this block. It pushes one 32-bit instruction word at a time into a single-entry slot, or it preloads a short sequence into an eight-word buffer and then releases that sequence so the hart fetches it back to back.

Data moves through a small load/store window on the hart side. A hart load from word 0x400 returns the last word the debugger wrote. A hart store to 0x400 captures a word that the debugger reads back. Four scratch words sit directly above 0x400. They hold addresses and results for a buffered sequence, so that sequence runs with no debugger round trip.

Misuse by either side raises one sticky error flag. Misuse means pushing into a full slot or a full buffer, reading data that was never captured, or a hart access outside the window. The flag stays set until the debugger clears it, so a long batch of operations can be issued blind and checked once at the end.

Top module: `dbg_feed`

## Requirements
- R1: After reset, fetch_rdy_o, dbg_err_o, dbg_data_o, fetch_insn_o and every scratch word are 0.
- R2: While halt_i is low, fetch_rdy_o is 0, and the slot and buffer are emptied and stay empty; instruction and buffer pushes made then are dropped without error. Scratch contents and the error flag are kept across a halt drop.
- R3: A word pushed with dbg_insn_we_i into the empty slot is offered on fetch_insn_o with fetch_rdy_o high from the next cycle until a cycle with fetch_req_i high consumes it. A push while the slot is occupied (checked on the state before the edge) sets the error and is discarded.
- R4: When no word is offered, fetch_rdy_o is 0 and fetch_insn_o is 0, so a fetch stalls and never sees a stale word.
- R5: A hart load at address 0x400 returns the last word written with dbg_data_we_i. A hart store at 0x400 appears on dbg_data_o from the next cycle and marks the word as captured.
- R6: dbg_data_re_i consumes the captured mark. If no store was captured since the last read, the read sets the error and dbg_data_o keeps its previous value.
- R7: dbg_buf_we_i appends dbg_insn_i to an 8-word FIFO. A push while it holds 8 words sets the error and is discarded. After dbg_buf_go_i, buffered words are offered in push order on consecutive fetches. Running stops one cycle after the buffer is seen empty. An occupied slot is always offered before the buffer.
- R8: Scratch word i (i = 0..3) sits at hart address 0x404 + 4*i. It is written by hart stores, or by the debugger with dbg_scr_we_i, dbg_scr_idx_i and dbg_data_i; if both write the same word in one cycle, the hart wins. The word is read by hart loads and on dbg_scr_o.
- R9: A hart access that is misaligned or outside 0x400..0x410 sets the error. A load there returns 0 and a store there changes nothing.
- R10: The error flag stays set until dbg_err_clr_i. A new error in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Hart is in debug halt |
| dbg_insn_i | input | 32 | Instruction word from the debugger |
| dbg_insn_we_i | input | 1 | Push dbg_insn_i into the single slot |
| dbg_buf_we_i | input | 1 | Append dbg_insn_i to the buffer |
| dbg_buf_go_i | input | 1 | Release the buffered sequence |
| dbg_data_i | input | 32 | Data word from the debugger |
| dbg_data_we_i | input | 1 | Write dbg_data_i to the 0x400 load value |
| dbg_data_re_i | input | 1 | Read strobe for the captured word |
| dbg_data_o | output | 32 | Last word the hart stored to 0x400 |
| dbg_scr_we_i | input | 1 | Write dbg_data_i to a scratch word |
| dbg_scr_idx_i | input | 2 | Scratch word index for debugger access |
| dbg_scr_o | output | 32 | Scratch word selected by dbg_scr_idx_i |
| dbg_err_o | output | 1 | Sticky error flag |
| dbg_err_clr_i | input | 1 | Clear the error flag |
| fetch_req_i | input | 1 | Hart fetch request |
| fetch_rdy_o | output | 1 | A word is offered; with fetch_req_i it is consumed |
| fetch_insn_o | output | 32 | Offered instruction word |
| hart_req_i | input | 1 | Hart data-window access |
| hart_we_i | input | 1 | Access is a store |
| hart_addr_i | input | 12 | Byte address of the access |
| hart_wdata_i | input | 32 | Store data |
| hart_rdata_o | output | 32 | Load data |

## Verification
The feed path is driven in three patterns. Lone pushes with the hart idle show that a word is held until it is consumed. A push onto an occupied slot is rejected, which separates a correct full check from one that overwrites. A preloaded buffer released while a single-slot word is also waiting shows slot-first priority, order, back-to-back issue and the stop when the buffer runs dry. A halt drop with work pending separates a flush from a pause. The data window is tried with a complete load-address, use, store-result sequence. It is also tried with repeated reads, in-range and out-of-range and misaligned addresses, and a clear that coincides with a fresh error.

// File: rtl/feed_pkg.sv
package feed_pkg;
  parameter int unsigned XLEN      = 32;
  parameter int unsigned AW        = 12;
  parameter int unsigned DATA_ADDR = 'h400;
  parameter int unsigned SCR_WORDS = 4;
  parameter int unsigned BUF_DEPTH = 8;
endpackage

// File: rtl/feed_fifo.sv
module feed_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [PW-1:0]           wp_q, rp_q;
  logic [CW-1:0]           cnt_q;
  logic                    do_push, do_pop;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (!do_push && do_pop) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end
endmodule

// File: rtl/feed_window.sv
module feed_window #(
  parameter int unsigned XW    = 32,
  parameter int unsigned AW    = 12,
  parameter int unsigned BASE  = 'h400,
  parameter int unsigned SCR_N = 4,
  localparam int unsigned SIW  = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dbg_we_i,
  input  logic [XW-1:0]  dbg_wdata_i,
  input  logic           dbg_re_i,
  output logic [XW-1:0]  dbg_rdata_o,
  output logic           cap_o,
  input  logic           scr_we_i,
  input  logic [SIW-1:0] scr_idx_i,
  output logic [XW-1:0]  scr_rdata_o,
  input  logic           hart_req_i,
  input  logic           hart_we_i,
  input  logic [AW-1:0]  hart_addr_i,
  input  logic [XW-1:0]  hart_wdata_i,
  output logic [XW-1:0]  hart_rdata_o,
  output logic           bad_addr_o
);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + 4 * SCR_N);

  logic [XW-1:0]            in_q, out_q;
  logic                     cap_q;
  logic [SCR_N-1:0][XW-1:0] scr_q;
  logic [AW-1:0]            off, widx;
  logic                     ok, data_hit;
  logic [SCR_N-1:0]         scr_hit;

  assign off        = hart_addr_i - LO;
  assign widx       = off >> 2;
  assign ok         = (hart_addr_i >= LO) && (hart_addr_i <= HI) && (off[1:0] == 2'b00);
  assign bad_addr_o = hart_req_i & ~ok;
  assign data_hit   = ok && (widx == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      cap_q <= 1'b0;
    end else begin
      if (dbg_we_i) in_q <= dbg_wdata_i;
      if (hart_req_i && hart_we_i && data_hit) begin
        out_q <= hart_wdata_i;
        cap_q <= 1'b1;
      end else if (dbg_re_i) begin
        cap_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < SCR_N; i++) begin : g_scr
    assign scr_hit[i] = ok && (widx == AW'(i + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   scr_q[i] <= '0;
      else if (hart_req_i && hart_we_i && scr_hit[i]) scr_q[i] <= hart_wdata_i;
      else if (scr_we_i && scr_idx_i == SIW'(i))      scr_q[i] <= dbg_wdata_i;
    end
  end

  always_comb begin
    hart_rdata_o = '0;
    if (data_hit) hart_rdata_o = in_q;
    for (int i = 0; i < SCR_N; i++) begin
      if (scr_hit[i]) hart_rdata_o = scr_q[i];
    end
  end

  assign dbg_rdata_o = out_q;
  assign cap_o       = cap_q;
  assign scr_rdata_o = scr_q[scr_idx_i];
endmodule

// File: rtl/dbg_feed.sv
module dbg_feed
  import feed_pkg::*;
#(
  parameter int unsigned XW    = XLEN,
  parameter int unsigned AWID  = AW,
  parameter int unsigned BASE  = DATA_ADDR,
  parameter int unsigned SCR_N = SCR_WORDS,
  parameter int unsigned DEPTH = BUF_DEPTH,
  localparam int unsigned SIW  = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            halt_i,
  input  logic [XW-1:0]   dbg_insn_i,
  input  logic            dbg_insn_we_i,
  input  logic            dbg_buf_we_i,
  input  logic            dbg_buf_go_i,
  input  logic [XW-1:0]   dbg_data_i,
  input  logic            dbg_data_we_i,
  input  logic            dbg_data_re_i,
  output logic [XW-1:0]   dbg_data_o,
  input  logic            dbg_scr_we_i,
  input  logic [SIW-1:0]  dbg_scr_idx_i,
  output logic [XW-1:0]   dbg_scr_o,
  output logic            dbg_err_o,
  input  logic            dbg_err_clr_i,
  input  logic            fetch_req_i,
  output logic            fetch_rdy_o,
  output logic [XW-1:0]   fetch_insn_o,
  input  logic            hart_req_i,
  input  logic            hart_we_i,
  input  logic [AWID-1:0] hart_addr_i,
  input  logic [XW-1:0]   hart_wdata_i,
  output logic [XW-1:0]   hart_rdata_o
);
  logic          slot_v_q, run_q, err_q;
  logic [XW-1:0] slot_q, buf_head;
  logic          buf_empty, buf_full, buf_pop, consume;
  logic          cap, bad_addr, early_rd, slot_ovf, buf_ovf, err_set;

  feed_fifo #(.W(XW), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (~halt_i),
    .push_i  (dbg_buf_we_i),
    .din_i   (dbg_insn_i),
    .pop_i   (buf_pop),
    .head_o  (buf_head),
    .empty_o (buf_empty),
    .full_o  (buf_full)
  );

  feed_window #(.XW(XW), .AW(AWID), .BASE(BASE), .SCR_N(SCR_N)) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dbg_we_i     (dbg_data_we_i),
    .dbg_wdata_i  (dbg_data_i),
    .dbg_re_i     (dbg_data_re_i),
    .dbg_rdata_o  (dbg_data_o),
    .cap_o        (cap),
    .scr_we_i     (dbg_scr_we_i),
    .scr_idx_i    (dbg_scr_idx_i),
    .scr_rdata_o  (dbg_scr_o),
    .hart_req_i   (hart_req_i),
    .hart_we_i    (hart_we_i),
    .hart_addr_i  (hart_addr_i),
    .hart_wdata_i (hart_wdata_i),
    .hart_rdata_o (hart_rdata_o),
    .bad_addr_o   (bad_addr)
  );

  // slot has priority over the buffer
  assign fetch_rdy_o  = halt_i & (slot_v_q | (run_q & ~buf_empty));
  assign fetch_insn_o = !fetch_rdy_o ? '0 : (slot_v_q ? slot_q : buf_head);
  assign consume      = fetch_req_i & fetch_rdy_o;
  assign buf_pop      = consume & ~slot_v_q;

  assign slot_ovf = halt_i & dbg_insn_we_i & slot_v_q;
  assign buf_ovf  = halt_i & dbg_buf_we_i & buf_full;
  assign early_rd = dbg_data_re_i & ~cap;
  assign err_set  = slot_ovf | buf_ovf | early_rd | bad_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_q <= 1'b0;
      slot_q   <= '0;
      run_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (!halt_i) begin
        slot_v_q <= 1'b0;
      end else if (dbg_insn_we_i && !slot_v_q) begin
        slot_v_q <= 1'b1;
        slot_q   <= dbg_insn_i;
      end else if (consume && slot_v_q) begin
        slot_v_q <= 1'b0;
      end
      run_q <= halt_i & (dbg_buf_go_i | (run_q & ~buf_empty));
      if (err_set)            err_q <= 1'b1;
      else if (dbg_err_clr_i) err_q <= 1'b0;
    end
  end

  assign dbg_err_o = err_q;
endmodule

// File: rtl/dbg_feed_chk.sv
module dbg_feed_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        halt_i,
  input logic        dbg_insn_we_i,
  input logic        dbg_buf_we_i,
  input logic        dbg_data_re_i,
  input logic        dbg_err_clr_i,
  input logic        dbg_err_o,
  input logic [31:0] dbg_data_o,
  input logic        fetch_rdy_o,
  input logic [31:0] fetch_insn_o,
  input logic        hart_req_i,
  input logic        hart_we_i,
  input logic [11:0] hart_addr_i,
  input logic [31:0] hart_wdata_i,
  input logic        slot_v_q,
  input logic        buf_full,
  input logic        cap
);
  logic addr_out;
  assign addr_out = (hart_addr_i[1:0] != 2'b00) || (hart_addr_i < 12'h400) || (hart_addr_i > 12'h410);

  a_r3_slot_busy_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && slot_v_q && dbg_insn_we_i |=> dbg_err_o);
  a_r7_buf_full_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && buf_full && dbg_buf_we_i |=> dbg_err_o);
  a_r6_early_read_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_data_re_i && !cap |=> dbg_err_o);
  a_r9_bad_addr_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hart_req_i && addr_out |=> dbg_err_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_err_o && !dbg_err_clr_i |=> dbg_err_o);
  a_r2_flush_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i |=> !slot_v_q);
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_rdy_o |-> fetch_insn_o == 32'h0);
  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hart_req_i && hart_we_i && hart_addr_i == 12'h400 |=> dbg_data_o == $past(hart_wdata_i));
endmodule

bind dbg_feed dbg_feed_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .halt_i        (halt_i),
  .dbg_insn_we_i (dbg_insn_we_i),
  .dbg_buf_we_i  (dbg_buf_we_i),
  .dbg_data_re_i (dbg_data_re_i),
  .dbg_err_clr_i (dbg_err_clr_i),
  .dbg_err_o     (dbg_err_o),
  .dbg_data_o    (dbg_data_o),
  .fetch_rdy_o   (fetch_rdy_o),
  .fetch_insn_o  (fetch_insn_o),
  .hart_req_i    (hart_req_i),
  .hart_we_i     (hart_we_i),
  .hart_addr_i   (hart_addr_i),
  .hart_wdata_i  (hart_wdata_i),
  .slot_v_q      (slot_v_q),
  .buf_full      (buf_full),
  .cap           (cap)
);

// File: tb/dbg_feed_tb_top.sv
`timescale 1ns/1ps
module dbg_feed_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        halt_i = 1'b0;
  logic [31:0] dbg_insn_i = '0;
  logic        dbg_insn_we_i = 1'b0, dbg_buf_we_i = 1'b0, dbg_buf_go_i = 1'b0;
  logic [31:0] dbg_data_i = '0;
  logic        dbg_data_we_i = 1'b0, dbg_data_re_i = 1'b0;
  logic [31:0] dbg_data_o;
  logic        dbg_scr_we_i = 1'b0;
  logic [1:0]  dbg_scr_idx_i = '0;
  logic [31:0] dbg_scr_o;
  logic        dbg_err_o;
  logic        dbg_err_clr_i = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic        fetch_rdy_o;
  logic [31:0] fetch_insn_o;
  logic        hart_req_i = 1'b0, hart_we_i = 1'b0;
  logic [11:0] hart_addr_i = 12'h400;
  logic [31:0] hart_wdata_i = '0;
  logic [31:0] hart_rdata_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit          m_slot_v, m_run, m_cap, m_err;
  bit [31:0]   m_slot, m_in, m_out;
  bit [31:0]   m_q[$];
  bit [31:0]   m_scr[4];

  always #2.5 clk_i = ~clk_i;

  dbg_feed dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit addr_ok(logic [11:0] a);
    return a[1:0] == 2'b00 && a >= 12'h400 && a <= 12'h410;
  endfunction

  function automatic bit [31:0] m_hrd(logic [11:0] a);
    if (!addr_ok(a)) return 32'h0;
    if (a == 12'h400) return m_in;
    return m_scr[(a - 12'h404) >> 2];
  endfunction

  task automatic compare();
    bit rdy;
    rdy = halt_i && (m_slot_v || (m_run && m_q.size() > 0));
    chk("R4 fetch_rdy", fetch_rdy_o, rdy);
    chk("R3 fetch_insn", fetch_insn_o, !rdy ? 32'h0 : (m_slot_v ? m_slot : m_q[0]));
    chk("R5 hart_rdata", hart_rdata_o, m_hrd(hart_addr_i));
    chk("R6 dbg_data", dbg_data_o, m_out);
    chk("R8 dbg_scr", dbg_scr_o, m_scr[dbg_scr_idx_i]);
    chk("R10 dbg_err", dbg_err_o, m_err);
  endtask

  task automatic model_step();
    int  sz = m_q.size();
    bit  rdy = halt_i && (m_slot_v || (m_run && sz > 0));
    bit  cons = fetch_req_i && rdy;
    bit  eset;
    eset = (halt_i && dbg_insn_we_i && m_slot_v) || (halt_i && dbg_buf_we_i && sz == 8) ||
           (dbg_data_re_i && !m_cap) || (hart_req_i && !addr_ok(hart_addr_i));
    if (!halt_i) begin
      m_slot_v = 0;
      m_q.delete();
    end else begin
      if (cons && !m_slot_v) void'(m_q.pop_front());
      if (dbg_buf_we_i && sz < 8) m_q.push_back(dbg_insn_i);
      if (dbg_insn_we_i && !m_slot_v) begin
        m_slot_v = 1; m_slot = dbg_insn_i;
      end else if (cons && m_slot_v) m_slot_v = 0;
    end
    m_run = halt_i && (dbg_buf_go_i || (m_run && sz > 0));
    if (dbg_data_we_i) m_in = dbg_data_i;
    if (dbg_scr_we_i) m_scr[dbg_scr_idx_i] = dbg_data_i;
    if (hart_req_i && hart_we_i && addr_ok(hart_addr_i)) begin
      if (hart_addr_i == 12'h400) begin
        m_out = hart_wdata_i; m_cap = 1;
      end else m_scr[(hart_addr_i - 12'h404) >> 2] = hart_wdata_i;
    end else if (dbg_data_re_i) m_cap = 0;
    if (eset) m_err = 1;
    else if (dbg_err_clr_i) m_err = 0;
  endtask

  task automatic tick();
    #1;
    compare();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    dbg_insn_we_i = 0; dbg_buf_we_i = 0; dbg_buf_go_i = 0;
    dbg_data_we_i = 0; dbg_data_re_i = 0; dbg_scr_we_i = 0;
    dbg_err_clr_i = 0; fetch_req_i = 0; hart_req_i = 0; hart_we_i = 0;
  endtask

  task automatic push(logic [31:0] w);
    dbg_insn_i = w; dbg_insn_we_i = 1; tick();
  endtask

  task automatic hart(bit we, logic [11:0] a, logic [31:0] d);
    hart_req_i = 1; hart_we_i = we; hart_addr_i = a; hart_wdata_i = d; tick();
  endtask

  task automatic clr_err();
    dbg_err_clr_i = 1; tick();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    #1;
    chk("R1 rdy", fetch_rdy_o, 0);
    chk("R1 err", dbg_err_o, 0);
    chk("R1 data", dbg_data_o, 0);
    chk("R1 insn", fetch_insn_o, 0);
    chk("R1 scr", dbg_scr_o, 0);
    @(negedge clk_i);

    halt_i = 1; tick();
    // R4 stall with nothing pending
    fetch_req_i = 1; tick();
    // R3 single slot hold, overflow
    push(32'h1111_0001);
    tick();
    chk("R3 held", fetch_insn_o, 32'h1111_0001);
    push(32'h2222_0002);
    chk("R3 overflow err", dbg_err_o, 1);
    fetch_req_i = 1; tick();
    tick();
    chk("R4 empty after consume", fetch_rdy_o, 0);
    clr_err();
    // R5/R6 load-use-store sequence
    dbg_data_i = 32'h0000_0410; dbg_data_we_i = 1; tick();
    push(32'h4000_2403);
    fetch_req_i = 1; tick();
    hart(0, 12'h400, 0);
    push(32'h0004_2403);
    fetch_req_i = 1; tick();
    hart(1, 12'h400, 32'hCAFE_F00D);
    chk("R5 captured", dbg_data_o, 32'hCAFE_F00D);
    dbg_data_re_i = 1; tick();
    chk("R6 first read ok", dbg_err_o, 0);
    dbg_data_re_i = 1; tick();
    chk("R6 early read err", dbg_err_o, 1);
    chk("R6 value kept", dbg_data_o, 32'hCAFE_F00D);
    // R10 clear coincident with new error keeps flag
    dbg_err_clr_i = 1; hart_req_i = 1; hart_addr_i = 12'h414; tick();
    chk("R10 set beats clear", dbg_err_o, 1);
    tick();
    chk("R10 sticky", dbg_err_o, 1);
    clr_err();
    chk("R10 cleared", dbg_err_o, 0);
    // R9 bad addresses
    hart(0, 12'h3FC, 0);
    chk("R9 below range", dbg_err_o, 1);
    clr_err();
    hart(1, 12'h406, 32'hDEAD_BEEF);
    chk("R9 misaligned", dbg_err_o, 1);
    clr_err();
    hart(1, 12'h414, 32'hDEAD_BEEF);
    clr_err();
    // R8 scratch
    dbg_data_i = 32'hA5A5_0000; dbg_scr_we_i = 1; dbg_scr_idx_i = 2'd1; tick();
    hart(0, 12'h408, 0);
    hart(1, 12'h410, 32'h5A5A_0003);
    dbg_scr_idx_i = 2'd3; tick();
    chk("R8 hart to scratch 3", dbg_scr_o, 32'h5A5A_0003);
    hart_req_i = 1; hart_we_i = 1; hart_addr_i = 12'h404; hart_wdata_i = 32'h0BAD_0000;
    dbg_scr_we_i = 1; dbg_scr_idx_i = 2'd0; dbg_data_i = 32'h1234_5678; tick();
    chk("R8 hart wins", dbg_scr_o, 32'h0BAD_0000);
    // R7 buffer fill, overflow, ordered run after slot
    for (int i = 0; i < 9; i++) begin
      dbg_insn_i = 32'hB000_0000 + i; dbg_buf_we_i = 1; tick();
    end
    chk("R7 full err", dbg_err_o, 1);
    clr_err();
    chk("R7 not run yet", fetch_rdy_o, 0);
    push(32'h5100_0000);
    dbg_buf_go_i = 1; tick();
    chk("R7 slot first", fetch_insn_o, 32'h5100_0000);
    for (int i = 0; i < 12; i++) begin
      fetch_req_i = 1; tick();
    end
    chk("R7 drained", fetch_rdy_o, 0);
    // R2 halt drop flushes slot and buffer, keeps scratch and error
    for (int i = 0; i < 3; i++) begin
      dbg_insn_i = 32'hC000_0000 + i; dbg_buf_we_i = 1; tick();
    end
    push(32'h5200_0000);
    hart(0, 12'h3F0, 0);
    halt_i = 0; tick();
    chk("R2 no rdy unhalted", fetch_rdy_o, 0);
    push(32'h5300_0000);
    dbg_insn_i = 32'hC100_0000; dbg_buf_we_i = 1; tick();
    halt_i = 1; dbg_buf_go_i = 1; tick();
    fetch_req_i = 1; tick();
    chk("R2 flushed", fetch_rdy_o, 0);
    chk("R2 err kept", dbg_err_o, 1);
    dbg_scr_idx_i = 2'd1; tick();
    chk("R2 scratch kept", dbg_scr_o, 32'hA5A5_0000);
    clr_err();
    repeat (2) tick();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule